// File: doc/BRIEF.md
# Signed Sequential Add-Shift Multiplier

This block multiplies two signed two's-complement operands over several clock cycles and returns a signed product twice as wide. It uses one adder/subtractor and a pair of shift registers. The upper half holds the running partial product and the lower half starts out as the multiplier. In each cycle the adder result is written back into the registers one bit to the right, so the add and the shift take a single clock edge together. The partial product's sign bit is copied in on every shift, so the shifts are arithmetic. On the final step the multiplier's sign bit has reached the examined position. If that bit is 1, the multiplicand is subtracted instead of added. All four sign combinations therefore come out correct without any separate negation of the operands or the result.

A controller with three states runs the sequence. In `ST_IDLE` the block waits. A `start` pulse moves it to `ST_STEP` (transition *launch*) and latches both operands. `ST_STEP` stays in place once for each remaining step (transition *iterate*). After the last step it goes to `ST_DONE` (transition *finish*). `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE` unconditionally (transition *release*). The default operand width is 4, which gives an 8-bit product.

Top module: `smul_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done` is 0 and `product` is all zeros.
- R2: A `start` seen high at a clock edge while idle is accepted. `done` then goes to 1 after the W-th following edge (edge 4 at the default width) and stays 1 for exactly one cycle.
- R3: When `done` is 1, `product` equals the signed two's-complement product of the accepted multiplicand and multiplier, as a 2W-bit value. This holds for every pair of operand values.
- R4: At the default width, the operand pairs (multiplicand, multiplier) 0111×0101, 1101×0101, 0101×1101 and 1011×1101 give 0x23, 0xF1, 0xF1 and 0x0F respectively.
- R5: Extreme operands do not overflow the intermediate sums. At W=4, 1000×1000 gives 0x40, 1000×0111 gives 0xC8 and 0111×1000 gives 0xC8.
- R6: After `start` is accepted, changes on `multiplicand` and `multiplier` have no effect on the result.
- R7: A `start` pulse that arrives while a multiplication is in progress is ignored. The `done` timing and the result of the running operation are unchanged.
- R8: After `done`, `product` holds its value until the next accepted `start`, whatever the operand inputs do.
- R9: A zero multiplicand or a zero multiplier gives a zero product, for either sign of the other operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiplication when the block is idle |
| multiplicand | input | W | Signed multiplicand, latched on accepted start |
| multiplier | input | W | Signed multiplier, latched on accepted start |
| product | output | 2W | Signed product; valid when done is 1, then held |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The bench goes after the sign corners. A design that used logical instead of arithmetic shifts would give wrong upper bits whenever the partial product turns negative. A design that added rather than subtracted on the last step would be wrong for every negative multiplier. It also drives the most negative operand on both sides: a 4-bit adder with no extra sign bit overflows on 1000×1000 and returns a negative product. Operand changes and a stray `start` during a run would expose a design that reads live inputs or restarts mid-sequence. A count kept off by one step would shift every product and move the `done` pulse.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_DONE = 2'd2
    } smul_state_t;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last_step,
    output logic done
);

    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    smul_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic at_last;

    assign at_last = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // step counter, cleared on launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)   state_d = ST_STEP;   // launch
            ST_STEP: if (at_last) state_d = ST_DONE;   // finish, else iterate
            ST_DONE:              state_d = ST_IDLE;   // release
            default:              state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        step      = 1'b0;
        last_step = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_STEP: begin
                step      = 1'b1;
                last_step = at_last;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/smul_addsub.sv
module smul_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] part_hi,
    input  logic [W-1:0] mcand,
    input  logic         take,
    input  logic         negate,
    output logic [W:0]   sum
);

    logic [W:0] hi_ext;
    logic [W:0] md_ext;
    logic [W:0] operand;

    // one guard bit so no sum can overflow
    assign hi_ext  = {part_hi[W-1], part_hi};
    assign md_ext  = {mcand[W-1], mcand};
    assign operand = take ? md_ext : '0;

    always_comb begin
        if (negate) begin
            sum = hi_ext - operand;
        end else begin
            sum = hi_ext + operand;
        end
    end

endmodule

// File: rtl/smul_regs.sv
module smul_regs #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mcand_in,
    input  logic [W-1:0] mplier_in,
    input  logic [W:0]   sum,
    output logic [W-1:0] part_hi,
    output logic [W-1:0] part_lo,
    output logic [W-1:0] mcand_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_hi <= '0;
            part_lo <= '0;
            mcand_q <= '0;
        end else if (load) begin
            part_hi <= '0;
            part_lo <= mplier_in;
            mcand_q <= mcand_in;
        end else if (step) begin
            // sum written one place right: add and shift in one edge
            part_hi <= sum[W:1];
            part_lo <= {sum[0], part_lo[W-1:1]};
        end
    end

endmodule

// File: rtl/smul_top.sv
module smul_top
    import smul_pkg::*;
#(
    parameter int W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   multiplicand,
    input  logic [W-1:0]   multiplier,
    output logic [2*W-1:0] product,
    output logic           done
);

    logic         load;
    logic         step;
    logic         last_step;
    logic [W-1:0] part_hi;
    logic [W-1:0] part_lo;
    logic [W-1:0] mcand_q;
    logic [W:0]   sum;

    smul_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .step      (step),
        .last_step (last_step),
        .done      (done)
    );

    smul_addsub #(.W(W)) u_addsub (
        .part_hi (part_hi),
        .mcand   (mcand_q),
        .take    (part_lo[0]),
        .negate  (last_step),
        .sum     (sum)
    );

    smul_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .mcand_in  (multiplicand),
        .mplier_in (multiplier),
        .sum       (sum),
        .part_hi   (part_hi),
        .part_lo   (part_lo),
        .mcand_q   (mcand_q)
    );

    assign product = {part_hi, part_lo};

endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int W = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   multiplicand,
    input logic [W-1:0]   multiplier,
    input logic [2*W-1:0] product,
    input logic           done
);

    logic           busy_c;
    logic [7:0]     cyc_c;
    logic [W-1:0]   cap_a;
    logic [W-1:0]   cap_b;
    logic signed [2*W-1:0] golden;

    assign golden = $signed(cap_a) * $signed(cap_b);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            cyc_c  <= '0;
            cap_a  <= '0;
            cap_b  <= '0;
        end else if (!busy_c) begin
            if (start) begin
                busy_c <= 1'b1;
                cyc_c  <= '0;
                cap_a  <= multiplicand;
                cap_b  <= multiplier;
            end
        end else if (done) begin
            busy_c <= 1'b0;
        end else begin
            cyc_c <= cyc_c + 1'b1;
        end
    end

    a_r2_done_after_steps: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_c && cyc_c == 8'(W)));

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // covers R3, R6 and R7: operands come from the accepted start only
    a_r3_product_value: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == golden));

    a_r8_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_c && !start) |=> $stable(product));

endmodule

bind smul_top smul_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .done         (done)
);

// File: tb/test_smul_top.sv
module test_smul_top;

    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   multiplicand = '0;
    logic [W-1:0]   multiplier = '0;
    logic [2*W-1:0] product;
    logic           done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    logic [2*W-1:0] exp_q[$];
    string          tag_q[$];

    always #10 clk = ~clk;

    smul_top #(.W(W)) i_smul_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .multiplicand (multiplicand),
        .multiplier   (multiplier),
        .product      (product),
        .done         (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: compares every done against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected done", {2*W{1'b0}}, {2*W{1'b0}});
                end else begin
                    logic [2*W-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(product === e, t, "product", product, e);
                end
            end
        end
    end

    // driver: pushes expected result, pulses start, checks done timing
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input string req, input bit disturb);
        int p;
        logic [2*W-1:0] e;
        p = int'($signed(a)) * int'($signed(b));
        e = p[2*W-1:0];
        @(negedge clk);
        multiplicand = a;
        multiplier   = b;
        start        = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        start = 1'b0;
        for (int k = 1; k <= W + 1; k++) begin
            @(negedge clk);
            check(done === (k == W), "R2", "done timing",
                  {{(2*W-1){1'b0}}, done}, {{(2*W-1){1'b0}}, k == W});
            if (disturb) begin
                if (k == 1) begin
                    multiplicand = ~a;      // R6: inputs change mid-run
                    multiplier   = a ^ b ^ 4'h5;
                end
                if (k == 2) start = 1'b1;   // R7: start while busy
                if (k == 3) start = 1'b0;
            end
        end
        // R8: idle with new operand values, product must hold
        multiplicand = b;
        multiplier   = ~a;
        @(negedge clk);
        @(negedge clk);
        check(product === e, "R8", "held product", product, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", {2*W{1'b0}}, {2*W{1'b0}});
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0, "R1", "done in reset", {{(2*W-1){1'b0}}, done}, '0);
        check(product === '0, "R1", "product in reset", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0, "R1", "done after reset", {{(2*W-1){1'b0}}, done}, '0);
        check(product === '0, "R1", "product after reset", product, '0);

        // R4 vectors
        run_op(4'b0111, 4'b0101, "R4", 1'b0);
        run_op(4'b1101, 4'b0101, "R4", 1'b0);
        run_op(4'b0101, 4'b1101, "R4", 1'b0);
        run_op(4'b1011, 4'b1101, "R4", 1'b0);
        check(1'b1, "R4", "vectors issued", '0, '0);

        // R5 extremes
        run_op(4'b1000, 4'b1000, "R5", 1'b0);
        run_op(4'b1000, 4'b0111, "R5", 1'b0);
        run_op(4'b0111, 4'b1000, "R5", 1'b0);

        // R9 zero operands
        run_op(4'b0000, 4'b1011, "R9", 1'b0);
        run_op(4'b1110, 4'b0000, "R9", 1'b0);
        run_op(4'b0000, 4'b0000, "R9", 1'b0);

        // R6 and R7: disturbed runs
        run_op(4'b1101, 4'b1011, "R6", 1'b1);
        run_op(4'b0110, 4'b1001, "R7", 1'b1);
        run_op(4'b1000, 4'b1000, "R7", 1'b1);

        // R3 every operand pair
        for (int i = 0; i < (1 << W); i++) begin
            for (int j = 0; j < (1 << W); j++) begin
                run_op(W'(i), W'(j), "R3", 1'b0);
            end
        end

        @(negedge clk);
        check(exp_q.size() == 0, "R2", "missing done pulses",
              2*W'(exp_q.size()), '0);
        finish_run();
    end

endmodule